// File: doc/BRIEF.md
# Signed Widening Vector Multiplier

This block multiplies two operand vectors of two's-complement integers lane by lane. Each product is exact and twice as wide as the lanes it comes from. A full set of doubled-width products needs twice the storage of one operand vector, so the unit returns it as a pair of result vectors, `res_lo` and `res_hi`, and each of them is as wide as one operand. The lower half of the lanes fills `res_lo` and the upper half fills `res_hi`. Within each result vector the lane order is kept. Two summary flags come back with every result: one reports that every product is zero, the other reports that at least one product is negative.

The lane width is chosen on each issue from byte, half, word or double. The lane width also sets the pipeline depth, so wider lanes take longer. The lane width of each operation travels with it, and the operation retires at its own latency. New work can be offered every cycle. If an offered operation would finish in the same cycle as one already in flight, `op_ready` is pulled low. The offer then waits, and no result is ever lost.

Top module: `wmul_top`

## Requirements
- R1: Every lane product equals the exact signed product of the two operand lanes, sign-extended multiplication, with no truncation or saturation.
- R2: With N lanes of E bits, the product of lane i < N/2 sits at `res_lo[i*2E +: 2E]`, and the product of lane i >= N/2 sits at `res_hi[(i-N/2)*2E +: 2E]`.
- R3: `op_width` encodes 0 = 8-bit, 1 = 16-bit, 2 = 32-bit and 3 = 64-bit lanes. An operation accepted in cycle c (`op_valid` and `op_ready` both high) shows `res_valid` high in cycle c+3, c+4, c+5 or c+6 respectively.
- R4: When no in-flight operation finishes in the cycle a new offer would finish, `op_ready` is high. Operations of one width can therefore be accepted every cycle.
- R5: `op_ready` is low exactly when an operation already in flight finishes in the cycle the offered width would finish. A stalled offer is not taken. Each accepted operation produces exactly one result.
- R6: `res_zero` is high with a result exactly when every product in it is zero.
- R7: `res_neg` is high with a result exactly when at least one product has its top bit set.
- R8: The most negative lane value times itself gives the positive value 2^(2E-2) in every lane, at every width.
- R9: While reset is held, `res_valid` is low and `op_ready` is high.
- R10: In any cycle with `res_valid` low, `res_lo`, `res_hi`, `res_zero` and `res_neg` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered this cycle |
| op_ready | output | 1 | Offer is taken this cycle |
| op_width | input | 2 | Lane width select |
| op_a | input | 128 | First operand vector |
| op_b | input | 128 | Second operand vector |
| res_valid | output | 1 | Result present this cycle |
| res_lo | output | 128 | Widened products of the lower lanes |
| res_hi | output | 128 | Widened products of the upper lanes |
| res_zero | output | 1 | All products zero |
| res_neg | output | 1 | Some product negative |

## Verification
The bench builds the block with its default parameters: 128-bit vectors, 8-bit base lanes, four widths and a base latency of 3. That range spans 16 byte lanes up to two 64-bit lanes with 128-bit products. Every width's most-negative square and every completion collision between widths three latency steps apart are reached with it. Mixed-width random traffic makes short operations overtake long ones. The bench's scoreboard matches results by completion cycle rather than by issue order.

// File: rtl/wmul_pkg.sv
package wmul_pkg;
    localparam int VEC_W     = 128;
    localparam int BASE_ELEM = 8;
    localparam int NUM_W     = 4;
    localparam int BASE_LAT  = 3;
    localparam int MAX_LAT   = BASE_LAT + NUM_W - 1;
    localparam int LAT_W     = $clog2(MAX_LAT + 2);
    localparam int SEL_W     = $clog2(NUM_W);
endpackage

// File: rtl/wmul_lanes.sv
module wmul_lanes #(
    parameter int VEC_W  = 128,
    parameter int ELEM_W = 8
) (
    input  logic [VEC_W-1:0] a,
    input  logic [VEC_W-1:0] b,
    output logic [VEC_W-1:0] r_lo,
    output logic [VEC_W-1:0] r_hi,
    output logic             all_zero,
    output logic             any_neg
);
    localparam int NL   = VEC_W / ELEM_W;
    localparam int PW   = 2 * ELEM_W;
    localparam int HALF = NL / 2;

    logic [NL-1:0] lane_nz;
    logic [NL-1:0] lane_neg;

    for (genvar i = 0; i < NL; i++) begin : g_lane
        logic [ELEM_W-1:0]   ea, eb;
        logic signed [PW-1:0] xa, xb, prod;
        assign ea   = a[i*ELEM_W +: ELEM_W];
        assign eb   = b[i*ELEM_W +: ELEM_W];
        assign xa   = {{ELEM_W{ea[ELEM_W-1]}}, ea};
        assign xb   = {{ELEM_W{eb[ELEM_W-1]}}, eb};
        assign prod = xa * xb;
        assign lane_nz[i]  = |prod;
        assign lane_neg[i] = prod[PW-1];
        if (i < HALF) begin : g_low
            assign r_lo[i*PW +: PW] = prod;
        end else begin : g_high
            assign r_hi[(i-HALF)*PW +: PW] = prod;
        end
    end

    assign all_zero = ~|lane_nz;
    assign any_neg  = |lane_neg;
endmodule

// File: rtl/wmul_retire.sv
module wmul_retire #(
    parameter int VEC_W   = 128,
    parameter int MAX_LAT = 6,
    parameter int LAT_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_valid,
    input  logic [LAT_W-1:0] ins_lat,
    input  logic [VEC_W-1:0] ins_lo,
    input  logic [VEC_W-1:0] ins_hi,
    input  logic             ins_zero,
    input  logic             ins_neg,
    input  logic [LAT_W-1:0] qry_lat,
    output logic             qry_free,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_lo,
    output logic [VEC_W-1:0] out_hi,
    output logic             out_zero,
    output logic             out_neg
);
    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] lo;
        logic [VEC_W-1:0] hi;
        logic             zero;
        logic             neg;
    } slot_t;

    typedef struct packed {
        slot_t [MAX_LAT:1] slot;
    } state_t;

    state_t st_d, st_q;
    logic   any_busy;

    always_comb begin
        st_d = st_q;
        for (int k = 1; k < MAX_LAT; k++) begin
            st_d.slot[k] = st_q.slot[k+1];
        end
        st_d.slot[MAX_LAT] = '0;
        for (int k = 1; k <= MAX_LAT; k++) begin
            if (ins_valid && (ins_lat == LAT_W'(k))) begin
                st_d.slot[k].valid = 1'b1;
                st_d.slot[k].lo    = ins_lo;
                st_d.slot[k].hi    = ins_hi;
                st_d.slot[k].zero  = ins_zero;
                st_d.slot[k].neg   = ins_neg;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        qry_free = 1'b1;
        for (int k = 1; k < MAX_LAT; k++) begin
            if ((qry_lat == LAT_W'(k)) && st_q.slot[k+1].valid) qry_free = 1'b0;
        end
        any_busy = 1'b0;
        for (int k = 1; k <= MAX_LAT; k++) any_busy = any_busy | st_q.slot[k].valid;
    end

    assign out_valid = st_q.slot[1].valid;
    assign out_lo    = st_q.slot[1].lo;
    assign out_hi    = st_q.slot[1].hi;
    assign out_zero  = st_q.slot[1].zero;
    assign out_neg   = st_q.slot[1].neg;

    assert_idle_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_lo == '0 && out_hi == '0 && !out_zero && !out_neg));
    assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_zero) |-> (out_lo == '0 && out_hi == '0));
    assert_neg_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_neg) |-> !out_zero);
    assert_idle_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !any_busy |-> qry_free);
endmodule

// File: rtl/wmul_top.sv
module wmul_top
    import wmul_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_valid,
    output logic               op_ready,
    input  logic [SEL_W-1:0]   op_width,
    input  logic [VEC_W-1:0]   op_a,
    input  logic [VEC_W-1:0]   op_b,
    output logic               res_valid,
    output logic [VEC_W-1:0]   res_lo,
    output logic [VEC_W-1:0]   res_hi,
    output logic               res_zero,
    output logic               res_neg
);
    logic [VEC_W-1:0] w_lo   [NUM_W];
    logic [VEC_W-1:0] w_hi   [NUM_W];
    logic [NUM_W-1:0] w_zero;
    logic [NUM_W-1:0] w_neg;

    for (genvar g = 0; g < NUM_W; g++) begin : g_width
        wmul_lanes #(
            .VEC_W  (VEC_W),
            .ELEM_W (BASE_ELEM << g)
        ) u_lanes (
            .a        (op_a),
            .b        (op_b),
            .r_lo     (w_lo[g]),
            .r_hi     (w_hi[g]),
            .all_zero (w_zero[g]),
            .any_neg  (w_neg[g])
        );
    end

    logic [LAT_W-1:0] lat;
    logic             free;
    logic             issue;

    assign lat      = LAT_W'(BASE_LAT) + LAT_W'(op_width);
    assign op_ready = free;
    assign issue    = op_valid && free;

    wmul_retire #(
        .VEC_W   (VEC_W),
        .MAX_LAT (MAX_LAT),
        .LAT_W   (LAT_W)
    ) u_retire (
        .clk       (clk),
        .rst_n     (rst_n),
        .ins_valid (issue),
        .ins_lat   (lat),
        .ins_lo    (w_lo[op_width]),
        .ins_hi    (w_hi[op_width]),
        .ins_zero  (w_zero[op_width]),
        .ins_neg   (w_neg[op_width]),
        .qry_lat   (lat),
        .qry_free  (free),
        .out_valid (res_valid),
        .out_lo    (res_lo),
        .out_hi    (res_hi),
        .out_zero  (res_zero),
        .out_neg   (res_neg)
    );

    assert_lat_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ready && op_width == 2'd0) |-> ##3 res_valid);
    assert_lat_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ready && op_width == 2'd1) |-> ##4 res_valid);
    assert_lat_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ready && op_width == 2'd2) |-> ##5 res_valid);
    assert_lat_dbl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ready && op_width == 2'd3) |-> ##6 res_valid);
endmodule

// File: tb/wmul_top_tb.sv
`timescale 1ns/1ps
module wmul_top_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid = 1'b0;
    logic         op_ready;
    logic [1:0]   op_width = '0;
    logic [127:0] op_a = '0, op_b = '0;
    logic         res_valid;
    logic [127:0] res_lo, res_hi;
    logic         res_zero, res_neg;

    always #2 clk = ~clk;

    wmul_top u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
        .op_width(op_width), .op_a(op_a), .op_b(op_b), .res_valid(res_valid),
        .res_lo(res_lo), .res_hi(res_hi), .res_zero(res_zero), .res_neg(res_neg)
    );

    typedef struct {
        logic [127:0] lo, hi;
        logic         z, n;
        int           due;
        string        tag;
    } exp_t;

    exp_t sb[$];
    int   cyc = 0;
    int   n_tests = 0, n_fail = 0;
    bit   done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string msg);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    function automatic void model(input int w, input logic [127:0] a, input logic [127:0] b,
                                  output exp_t e);
        int e_w, nl, pw;
        logic [127:0] emask, pmask, xa, xb, p;
        e_w = 8 << w; nl = 128 / e_w; pw = 2 * e_w;
        emask = (128'd1 << e_w) - 128'd1;
        pmask = (128'd1 << pw) - 128'd1;
        e.lo = '0; e.hi = '0; e.z = 1'b1; e.n = 1'b0;
        for (int i = 0; i < nl; i++) begin
            xa = (a >> (i * e_w)) & emask;
            xb = (b >> (i * e_w)) & emask;
            if (xa[e_w-1]) xa = xa | ~emask;
            if (xb[e_w-1]) xb = xb | ~emask;
            p = ($signed(xa) * $signed(xb)) & pmask;
            if (p != '0) e.z = 1'b0;
            if (p[pw-1]) e.n = 1'b1;
            if (i < nl / 2) e.lo = e.lo | (p << (i * pw));
            else            e.hi = e.hi | (p << ((i - nl / 2) * pw));
        end
    endfunction

    // Called at a falling edge; returns at a falling edge once accepted.
    task automatic issue(input int w, input logic [127:0] a, input logic [127:0] b,
                         input exp_t e, output int stalls);
        bit busy;
        stalls = 0;
        op_valid = 1'b1; op_width = w[1:0]; op_a = a; op_b = b;
        forever begin
            #1;
            busy = 0;
            foreach (sb[k]) if (sb[k].due == cyc + 3 + w) busy = 1;
            chk(op_ready == !busy, "R5",
                $sformatf("op_ready=%0b expected %0b (width %0d)", op_ready, !busy, w));
            if (op_ready) begin
                e.due = cyc + 3 + w;
                sb.push_back(e);
                @(negedge clk);
                break;
            end
            stalls++;
            @(negedge clk);
        end
        op_valid = 1'b0;
    endtask

    task automatic push_model(input int w, input logic [127:0] a, input logic [127:0] b,
                              input string tag);
        exp_t e; int s;
        model(w, a, b, e);
        e.tag = tag;
        issue(w, a, b, e, s);
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    // Result monitor: matches by completion cycle
    always @(negedge clk) begin
        int idx;
        if (rst_n && !done) begin
            idx = -1;
            foreach (sb[k]) if (sb[k].due == cyc) idx = k;
            chk(res_valid == (idx >= 0), "R3",
                $sformatf("res_valid=%0b expected %0b at cycle %0d", res_valid, idx >= 0, cyc));
            if (res_valid && idx >= 0) begin
                chk(res_lo == sb[idx].lo, {sb[idx].tag, " R1 R2"},
                    $sformatf("res_lo=%h expected %h", res_lo, sb[idx].lo));
                chk(res_hi == sb[idx].hi, {sb[idx].tag, " R1 R2"},
                    $sformatf("res_hi=%h expected %h", res_hi, sb[idx].hi));
                chk(res_zero == sb[idx].z, "R6",
                    $sformatf("res_zero=%0b expected %0b", res_zero, sb[idx].z));
                chk(res_neg == sb[idx].n, "R7",
                    $sformatf("res_neg=%0b expected %0b", res_neg, sb[idx].n));
                sb.delete(idx);
            end
            if (!res_valid) begin
                chk(res_lo == '0 && res_hi == '0 && !res_zero && !res_neg, "R10",
                    $sformatf("idle outputs lo=%h hi=%h z=%0b n=%0b expected all 0",
                              res_lo, res_hi, res_zero, res_neg));
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (!done && cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: run hung at cycle %0d, expected completion", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int st;
        exp_t e;
        logic [127:0] mn, mexp;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(res_valid == 1'b0, "R9", $sformatf("res_valid=%0b expected 0", res_valid));
        chk(op_ready == 1'b1, "R9", $sformatf("op_ready=%0b expected 1", op_ready));
        rst_n = 1'b1;
        @(negedge clk);

        // R8: most negative value squared, every width, expected built directly
        for (int w = 0; w < 4; w++) begin
            int ew, pw;
            ew = 8 << w; pw = 2 * ew;
            mn = '0; mexp = '0;
            for (int i = 0; i < 128 / ew; i++) mn = mn | ((128'd1 << (ew - 1)) << (i * ew));
            for (int i = 0; i < 64 / ew; i++) mexp = mexp | ((128'd1 << (pw - 2)) << (i * pw));
            e.lo = mexp; e.hi = mexp; e.z = 1'b0; e.n = 1'b0; e.tag = "R8";
            issue(w, mn, mn, e, st);
            repeat (7) @(negedge clk);
        end

        // R6 zero operand, R7 all-negative, R1 R2 random per width
        for (int w = 0; w < 4; w++) begin
            push_model(w, '0, rnd128(), "R6");
            repeat (7) @(negedge clk);
            push_model(w, {128{1'b1}}, {16{8'h01}}, "R7");
            repeat (7) @(negedge clk);
            for (int k = 0; k < 3; k++) begin
                push_model(w, rnd128(), rnd128(), "R1");
                repeat (7) @(negedge clk);
            end
        end

        // R4: same width back to back, never stalled
        for (int w = 0; w < 4; w++) begin
            for (int k = 0; k < 6; k++) begin
                model(w, rnd128(), rnd128(), e);
                mn = rnd128(); mexp = rnd128();
                model(w, mn, mexp, e); e.tag = "R4";
                issue(w, mn, mexp, e, st);
                chk(st == 0, "R4", $sformatf("stalls=%0d expected 0", st));
            end
            repeat (7) @(negedge clk);
        end

        // R5: double then byte three cycles later collide -> one stall
        push_model(3, rnd128(), rnd128(), "R5");
        repeat (2) @(negedge clk);
        mn = rnd128(); mexp = rnd128();
        model(0, mn, mexp, e); e.tag = "R5";
        issue(0, mn, mexp, e, st);
        chk(st == 1, "R5", $sformatf("stalls=%0d expected 1", st));
        repeat (8) @(negedge clk);

        // Mixed random traffic with overtaking and stalls
        for (int k = 0; k < 300; k++) begin
            int w;
            w = int'($urandom_range(0, 3));
            push_model(w, rnd128(), rnd128(), "R1");
            if ($urandom_range(0, 3) == 0) @(negedge clk);
        end

        for (int k = 0; k < 20 && sb.size() != 0; k++) @(negedge clk);
        chk(sb.size() == 0, "R5", $sformatf("undelivered=%0d expected 0", sb.size()));
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule